// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment:offset pair into a physical byte address in the way a 16-bit segmented processor does in real mode. A bank of four 16-bit segment registers is loaded through a write port. An access request names one of them and supplies a 16-bit offset. One clock later the block returns the linear address, which is also the physical address, with a valid flag.

The segment value is shifted left by four bits to form a base on a 16-byte paragraph boundary, and the offset is added to it. Segments are up to 64 KB long and their bases are only 16 bytes apart, so many different pairs can name the same byte. Sums above the 1 MB space are handled by a high-line gate input. With the gate closed, the result wraps to the bottom of memory. With the gate open, the carry appears on a 21st address bit.

Top module: `rm_addr_gen`

## Requirements
- R1: The result is (segment × 16) + offset, so 06EFh:1234h gives 08124h and 000Ch:000Fh gives 000CFh.
- R2: With `hi_gate_open` low, the result is taken modulo 2^20 and bit 20 is zero. FFFFh:0010h gives 00000h, FFFDh:03E8h gives 003B8h and FFFFh:FFFFh gives 0FFEFh.
- R3: With `hi_gate_open` high, the 21-bit sum is kept and bit 20 carries the overflow. FFFFh:FFFFh gives 10FFEFh and FFFFh:0010h gives 100000h.
- R4: There are four segment registers, chosen by a 2-bit select: 0 code, 1 data, 2 stack, 3 extra. Each is written with `ld_value` when `ld_en` is high at a clock edge and `ld_sel` names it.
- R5: Reset clears all four segment registers to zero, clears `rsp_valid` and sets `rsp_addr` to zero.
- R6: When a load and a request name the same register in the same cycle, the request uses the newly loaded value. A load to a different register does not change that request.
- R7: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R8: `hi_gate_open` is sampled with the request. Changing it afterwards does not alter a result that has already been issued.
- R9: Different segment:offset pairs that have the same sum give the same address, for example 0100h:0000h and 00FFh:0010h both give 01000h.
- R10: `rsp_addr` keeps its last value in cycles without a response.
- R11: The low four bits of the result equal the low four bits of the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Segment register write enable |
| ld_sel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| ld_value | input | 16 | New segment value |
| req_valid | input | 1 | Address request strobe |
| req_sel | input | 2 | Segment register used by the request |
| req_offset | input | 16 | Offset within the segment |
| hi_gate_open | input | 1 | 1 keeps the carry into bit 20, 0 wraps at 1 MB |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 21 | Physical byte address |

## Verification
The assertions assume that `req_valid`, `ld_en` and `hi_gate_open` are driven to known levels once reset is released. They also assume that reset is held for at least one clock edge, so the response register starts from its cleared state. The bench changes every input only at the falling edge and keeps each of them at 0 or 1 at all times. It holds `req_valid` low during reset and raises it only after `rst_n` has risen, so every property starts from a defined history.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;
  localparam int SEG_W      = 16;
  localparam int OFF_W      = 16;
  localparam int PARA_SHIFT = 4;
  localparam int NUM_SEGS   = 4;
  localparam int SEL_W      = $clog2(NUM_SEGS);
  localparam int BASE_W     = SEG_W + PARA_SHIFT;
  localparam int ADDR_W     = BASE_W + 1;

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_sel_e;
endpackage

// File: rtl/seg_reg_bank.sv
module seg_reg_bank #(
  parameter int NUM_SEGS = 4,
  parameter int SEG_W    = 16,
  localparam int SEL_W   = $clog2(NUM_SEGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_data,
  output logic             fwd_hit
);
  logic [SEG_W-1:0] seg_q [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic wr_here;
    assign wr_here = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seg_q[g] <= '0;
      else if (wr_here) seg_q[g] <= wr_data;
    end
  end

  // bypass the register when the same entry is written this cycle
  assign fwd_hit = wr_en && (wr_sel == rd_sel);
  assign rd_data = fwd_hit ? wr_data : seg_q[rd_sel];
endmodule

// File: rtl/seg_lin_adder.sv
module seg_lin_adder #(
  parameter int SEG_W      = 16,
  parameter int OFF_W      = 16,
  parameter int PARA_SHIFT = 4,
  localparam int BASE_W    = SEG_W + PARA_SHIFT,
  localparam int ADDR_W    = BASE_W + 1
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic              gate_open,
  output logic [ADDR_W-1:0] lin,
  output logic              carry_raw
);
  function automatic logic [ADDR_W-1:0] para_base(input logic [SEG_W-1:0] s);
    return {1'b0, s, {PARA_SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] full_sum(input logic [SEG_W-1:0] s,
                                                 input logic [OFF_W-1:0] o);
    return para_base(s) + {{(ADDR_W-OFF_W){1'b0}}, o};
  endfunction

  logic [ADDR_W-1:0] sum_w;
  assign sum_w     = full_sum(seg, off);
  assign carry_raw = sum_w[ADDR_W-1];
  assign lin       = {carry_raw & gate_open, sum_w[BASE_W-1:0]};
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= in_addr;
    end
  end
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen
  import rm_addr_pkg::*;
#(
  parameter int P_SEG_W    = SEG_W,
  parameter int P_OFF_W    = OFF_W,
  parameter int P_SHIFT    = PARA_SHIFT,
  parameter int P_NUM_SEGS = NUM_SEGS,
  localparam int P_SEL_W   = $clog2(P_NUM_SEGS),
  localparam int P_ADDR_W  = P_SEG_W + P_SHIFT + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic [P_SEL_W-1:0]  ld_sel,
  input  logic [P_SEG_W-1:0]  ld_value,
  input  logic                req_valid,
  input  logic [P_SEL_W-1:0]  req_sel,
  input  logic [P_OFF_W-1:0]  req_offset,
  input  logic                hi_gate_open,
  output logic                rsp_valid,
  output logic [P_ADDR_W-1:0] rsp_addr
);
  logic [P_SEG_W-1:0]  seg_val;
  logic                fwd_hit;
  logic [P_ADDR_W-1:0] lin_addr;
  logic                carry_raw;

  seg_reg_bank #(.NUM_SEGS(P_NUM_SEGS), .SEG_W(P_SEG_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_en), .wr_sel(ld_sel), .wr_data(ld_value),
    .rd_sel(req_sel), .rd_data(seg_val), .fwd_hit(fwd_hit)
  );

  seg_lin_adder #(.SEG_W(P_SEG_W), .OFF_W(P_OFF_W), .PARA_SHIFT(P_SHIFT)) u_add (
    .seg(seg_val), .off(req_offset), .gate_open(hi_gate_open),
    .lin(lin_addr), .carry_raw(carry_raw)
  );

  seg_out_stage #(.ADDR_W(P_ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_addr(lin_addr),
    .out_valid(rsp_valid), .out_addr(rsp_addr)
  );
endmodule

// File: rtl/rm_addr_gen_chk.sv
module rm_addr_gen_chk #(
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [OFF_W-1:0]  req_offset,
  input logic              hi_gate_open,
  input logic              carry_raw,
  input logic              fwd_hit,
  input logic              ld_en,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr
);
  assert_rsp_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_without_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_wrap_clears_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hi_gate_open) |=> !rsp_addr[ADDR_W-1]);
  assert_open_keeps_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hi_gate_open && carry_raw) |=> rsp_addr[ADDR_W-1]);
  assert_low_nibble_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_addr[3:0] == $past(req_offset[3:0])));
  assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_addr));
  assert_fwd_needs_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> ld_en);
endmodule

bind rm_addr_gen rm_addr_gen_chk #(.OFF_W(P_OFF_W), .ADDR_W(P_ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
  .hi_gate_open(hi_gate_open), .carry_raw(carry_raw), .fwd_hit(fwd_hit),
  .ld_en(ld_en), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
);

// File: tb/rm_addr_gen_bench.sv
module rm_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_value = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_sel = '0;
  logic [15:0] req_offset = '0;
  logic        hi_gate_open = 1'b0;
  logic        rsp_valid;
  logic [20:0] rsp_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit run = 1'b0;
  logic [20:0] exp_q [$];
  string       tag_q [$];
  logic [20:0] last_addr = '0;
  logic [15:0] mdl_seg [4];

  always #4 clk = ~clk;

  rm_addr_gen u_rm_addr_gen (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_value(ld_value),
    .req_valid(req_valid), .req_sel(req_sel), .req_offset(req_offset),
    .hi_gate_open(hi_gate_open), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
  );

  function automatic logic [20:0] model(input logic [15:0] s, input logic [15:0] o,
                                        input bit gate);
    int t;
    t = int'(s) * 16 + int'(o);
    if (!gate) t = t % 1048576;
    return 21'(t);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [20:0] act,
                       input logic [20:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic idle(input bit gate);
    @(negedge clk);
    ld_en = 1'b0; req_valid = 1'b0; hi_gate_open = gate;
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_value = val; req_valid = 1'b0;
    mdl_seg[sel] = val;
  endtask

  task automatic issue(input logic [1:0] sel, input logic [15:0] off, input bit gate,
                       input logic [20:0] exp, input string tag);
    @(negedge clk);
    ld_en = 1'b0; req_valid = 1'b1; req_sel = sel; req_offset = off; hi_gate_open = gate;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic issue_ld(input logic [1:0] lsel, input logic [15:0] val,
                          input logic [1:0] sel, input logic [15:0] off,
                          input logic [20:0] exp, input string tag);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = lsel; ld_value = val;
    req_valid = 1'b1; req_sel = sel; req_offset = off; hi_gate_open = 1'b0;
    mdl_seg[lsel] = val;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  // monitor: samples just after each rising edge
  always @(posedge clk) begin
    #1;
    if (run) begin
      if (exp_q.size() > 0) begin
        logic [20:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_valid === 1'b1, {t, " valid"}, {20'd0, rsp_valid}, 21'd1);
        check(rsp_addr === e, t, rsp_addr, e);
        last_addr = rsp_addr;
      end else begin
        check(rsp_valid === 1'b0, "R7 idle valid", {20'd0, rsp_valid}, 21'd0);
        check(rsp_addr === last_addr, "R10 hold", rsp_addr, last_addr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%06h expected=%06h", 21'd0, 21'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4; i++) mdl_seg[i] = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R5 reset valid", {20'd0, rsp_valid}, 21'd0);
    check(rsp_addr === 21'd0, "R5 reset addr", rsp_addr, 21'd0);
    rst_n = 1'b1;
    run = 1'b1;

    // R5: registers cleared, so each gives the bare offset
    for (int i = 0; i < 4; i++) issue(2'(i), 16'h0012, 1'b0, 21'h00012, "R5 cleared seg");
    idle(1'b0);

    // R4: load all four (0 code, 1 data, 2 stack, 3 extra)
    load(2'd0, 16'h06EF); load(2'd1, 16'h000C); load(2'd2, 16'hFFFF); load(2'd3, 16'hFFFD);
    issue(2'd0, 16'h1234, 1'b0, 21'h08124, "R1 R4 code");
    issue(2'd1, 16'h000F, 1'b0, 21'h000CF, "R1 R4 data");
    issue(2'd2, 16'h0010, 1'b0, 21'h00000, "R2 wrap to zero");
    issue(2'd3, 16'h03E8, 1'b0, 21'h003B8, "R2 wrap 952");
    issue(2'd2, 16'hFFFF, 1'b0, 21'h0FFEF, "R2 wrap top");
    issue(2'd2, 16'hFFFF, 1'b1, 21'h10FFEF, "R3 carry kept");
    issue(2'd2, 16'h0010, 1'b1, 21'h100000, "R3 just over");
    // R8: gate flips right after an open-gate request
    issue(2'd2, 16'h0020, 1'b1, 21'h100010, "R8 sampled open");
    issue(2'd2, 16'h0020, 1'b0, 21'h00010, "R8 sampled closed");
    idle(1'b1); idle(1'b0);

    // R9: aliasing pairs
    load(2'd0, 16'h0100); load(2'd1, 16'h00FF);
    issue(2'd0, 16'h0000, 1'b0, 21'h01000, "R9 alias a");
    issue(2'd1, 16'h0010, 1'b0, 21'h01000, "R9 alias b");
    idle(1'b0);

    // R6: forwarding to same register, none across registers
    issue_ld(2'd3, 16'h1234, 2'd3, 16'h0005, 21'h12345, "R6 forwarded");
    issue(2'd3, 16'h0000, 1'b0, 21'h12340, "R6 stored");
    issue_ld(2'd0, 16'h2000, 2'd1, 16'h0000, 21'h00FF0, "R6 other reg");
    issue(2'd0, 16'h0001, 1'b0, 21'h20001, "R6 other stored");
    idle(1'b0);

    // R1: pseudo-random sweep checked against the bench model
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      logic [15:0] o;
      bit g;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 5 == 0) load(lf[1:0], lf ^ 16'h5A5A);
      o = {lf[7:0], lf[15:8]};
      g = lf[3];
      issue(lf[5:4], o, g, model(mdl_seg[lf[5:4]], o, g), "R1 sweep");
      if (i % 7 == 0) idle(~g);
    end
    idle(1'b0); idle(1'b0); idle(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule